// File: doc/BRIEF.md
# Power-Management Event Status and SCI Generator

This block keeps the event-status and event-enable state of a power-management controller and turns it into one level-sensitive system control interrupt (`sci`). It holds a 16-bit main status register, a 16-bit main enable register, and a parameterised general-purpose event (GPE) status and enable pair. Hardware event pulses (power button, real-time-clock alarm, generic GPE lines) set status bits. Software reads the registers over a small I/O bus, clears status bits by writing ones, and chooses which events may interrupt by writing the enable registers.

The interrupt is recomputed from the registered state on every cycle. It is high while at least one enabled status bit is set and falls once software clears the last such bit or disables it. The bus carries an access-size code, and each register answers only to its own width. An access of the wrong size leaves every register unchanged and reads back zero. The producers of the events and the routing of the interrupt are outside this block.

Register select `bus_addr`: 0 = main status, 1 = main enable, 2 = GPE status, 3 = GPE enable. Size code `bus_size`: 0 = one byte, 1 = two bytes, 2 = four bytes, 3 = reserved.

Top module: `pm_evt_sci`

## Requirements
- R1: After reset, all four registers read zero and `sci` is low.
- R2: A two-byte write to the main status register clears each bit of mask 0x8710 (bits 15, 10, 9, 8, 4) where the written data is 1. Data bits that are 0, and data bits outside that mask, leave status unchanged.
- R3: A two-byte write to the main enable register stores the data ANDed with 0x0520 (bits 10, 8, 5). Every other enable bit reads 0.
- R4: `sci` is a level, high exactly while (main enable AND main status AND 0x0721) is nonzero or (GPE enable AND GPE status) is nonzero. It follows a register change in the cycle after the clock edge that made the change, and it holds high for as long as the condition lasts.
- R5: A `pwrbtn_evt` pulse sets status bit 8 only while `btn_arm` is high; with `btn_arm` low it is ignored. An `rtc_evt` pulse sets status bit 10 whatever `btn_arm` is.
- R6: A `gpe_evt` line sets its GPE status bit only if that bit is in `GPE_VALID` (default 0x01). A one-byte GPE status write clears the written ones within `GPE_VALID`. A one-byte GPE enable write stores the data ANDed with `GPE_VALID`.
- R7: The main registers accept only two-byte accesses (size 1), and the GPE registers accept only one-byte accesses (size 0). A write of any other size changes nothing, and a read of any other size returns zero.
- R8: If an event arrives in the same cycle as a write that clears its status bit, the event wins and the bit stays set.
- R9: `bus_rdata` shows the selected register, zero-extended to 16 bits, in the same cycle as an accepted read. It is zero whenever no accepted read is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select (0 main status, 1 main enable, 2 GPE status, 3 GPE enable) |
| bus_size | input | 2 | Access size code (0 byte, 1 two bytes, 2 four bytes, 3 reserved) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| btn_arm | input | 1 | Power-button events honoured while high |
| rtc_evt | input | 1 | Real-time-clock alarm event pulse |
| gpe_evt | input | GPE_W | Generic event lines, one per GPE status bit |
| sci | output | 1 | Level-sensitive system control interrupt |

## Verification
The assertions assume that every input has a known value at each rising edge, and that `rst_n` is low from time zero until the first edges have passed. They also assume that a bus access lasts one cycle and that bus fields are defined while `bus_valid` is high. The bench keeps within these assumptions. It sets every input to a defined value before reset is released, changes inputs only on the falling clock edge, and drops `bus_valid` after each single-cycle access. Event pulses and clearing writes are driven both in separate cycles and in the same cycle, so that the event-over-clear rule is reached without breaking the one-access-per-cycle assumption.

// File: rtl/pm_evt_pkg.sv
`timescale 1ns/1ps
package pm_evt_pkg;

    // Main status bits that software may clear by writing one
    localparam logic [15:0] MAIN_STS_CLR_MASK = 16'h8710;
    // Main enable bits that software may store
    localparam logic [15:0] MAIN_EN_WR_MASK   = 16'h0520;
    // Status/enable pairs that feed the interrupt
    localparam logic [15:0] MAIN_IRQ_PAIRS    = 16'h0721;

    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;

    typedef enum logic [1:0] {
        SEL_MAIN_STS = 2'd0,
        SEL_MAIN_EN  = 2'd1,
        SEL_GPE_STS  = 2'd2,
        SEL_GPE_EN   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic main_sts;
        logic main_en;
        logic gpe_sts;
        logic gpe_en;
    } wr_strb_t;

endpackage

// File: rtl/pm_bus_decode.sv
`timescale 1ns/1ps
module pm_bus_decode
    import pm_evt_pkg::*;
#(
    parameter int GPE_W = 8
) (
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [15:0]      main_sts_q,
    input  logic [15:0]      main_en_q,
    input  logic [GPE_W-1:0] gpe_sts_q,
    input  logic [GPE_W-1:0] gpe_en_q,
    output wr_strb_t         wstrb,
    output logic [15:0]      bus_rdata
);

    reg_sel_e    sel;
    acc_size_e   size;
    logic        size_ok;
    logic        rd_ok;
    logic [15:0] gpe_sts_ext;
    logic [15:0] gpe_en_ext;

    always_comb begin
        sel  = reg_sel_e'(bus_addr);
        size = acc_size_e'(bus_size);
        // main registers answer to two-byte accesses, GPE registers to single bytes
        if ((sel == SEL_MAIN_STS) || (sel == SEL_MAIN_EN)) begin
            size_ok = (size == SZ_HALF);
        end else begin
            size_ok = (size == SZ_BYTE);
        end
    end

    always_comb begin
        wstrb          = '0;
        wstrb.main_sts = bus_valid && bus_write && size_ok && (sel == SEL_MAIN_STS);
        wstrb.main_en  = bus_valid && bus_write && size_ok && (sel == SEL_MAIN_EN);
        wstrb.gpe_sts  = bus_valid && bus_write && size_ok && (sel == SEL_GPE_STS);
        wstrb.gpe_en   = bus_valid && bus_write && size_ok && (sel == SEL_GPE_EN);
    end

    always_comb begin
        gpe_sts_ext = '0;
        gpe_en_ext  = '0;
        gpe_sts_ext[GPE_W-1:0] = gpe_sts_q;
        gpe_en_ext[GPE_W-1:0]  = gpe_en_q;
        rd_ok     = bus_valid && !bus_write && size_ok;
        bus_rdata = '0;
        if (rd_ok) begin
            unique case (sel)
                SEL_MAIN_STS: bus_rdata = main_sts_q;
                SEL_MAIN_EN:  bus_rdata = main_en_q;
                SEL_GPE_STS:  bus_rdata = gpe_sts_ext;
                SEL_GPE_EN:   bus_rdata = gpe_en_ext;
                default:      bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pm_evt_regs.sv
`timescale 1ns/1ps
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = 'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_strb_t         wstrb,
    input  logic [15:0]      wdata,
    input  logic             pwrbtn_evt,
    input  logic             btn_arm,
    input  logic             rtc_evt,
    input  logic [GPE_W-1:0] gpe_evt,
    output logic [15:0]      main_sts_q,
    output logic [15:0]      main_en_q,
    output logic [GPE_W-1:0] gpe_sts_q,
    output logic [GPE_W-1:0] gpe_en_q
);

    typedef struct packed {
        logic [15:0]      main_sts;
        logic [15:0]      main_en;
        logic [GPE_W-1:0] gpe_sts;
        logic [GPE_W-1:0] gpe_en;
    } state_t;

    state_t           st_d, st_q;
    logic [15:0]      main_set, main_clr;
    logic [GPE_W-1:0] gpe_set, gpe_clr;

    always_comb begin
        st_d = st_q;

        main_set             = '0;
        main_set[BIT_PWRBTN] = pwrbtn_evt && btn_arm;
        main_set[BIT_RTC]    = rtc_evt;
        main_clr             = wstrb.main_sts ? (wdata & MAIN_STS_CLR_MASK) : '0;
        // set after clear: a same-cycle event keeps its bit
        st_d.main_sts = (st_q.main_sts & ~main_clr) | main_set;

        if (wstrb.main_en) begin
            st_d.main_en = wdata & MAIN_EN_WR_MASK;
        end

        gpe_set      = gpe_evt & GPE_VALID;
        gpe_clr      = wstrb.gpe_sts ? (wdata[GPE_W-1:0] & GPE_VALID) : '0;
        st_d.gpe_sts = (st_q.gpe_sts & ~gpe_clr) | gpe_set;

        if (wstrb.gpe_en) begin
            st_d.gpe_en = wdata[GPE_W-1:0] & GPE_VALID;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign main_sts_q = st_q.main_sts;
    assign main_en_q  = st_q.main_en;
    assign gpe_sts_q  = st_q.gpe_sts;
    assign gpe_en_q   = st_q.gpe_en;

endmodule

// File: rtl/pm_sci_gen.sv
`timescale 1ns/1ps
module pm_sci_gen
    import pm_evt_pkg::*;
#(
    parameter int GPE_W = 8
) (
    input  logic [15:0]      main_sts_q,
    input  logic [15:0]      main_en_q,
    input  logic [GPE_W-1:0] gpe_sts_q,
    input  logic [GPE_W-1:0] gpe_en_q,
    output logic             sci
);

    logic [15:0]      pair_hit;
    logic [GPE_W-1:0] gpe_hit;

    for (genvar i = 0; i < 16; i++) begin : g_pair
        if (MAIN_IRQ_PAIRS[i]) begin : g_used
            assign pair_hit[i] = main_en_q[i] & main_sts_q[i];
        end else begin : g_unused
            assign pair_hit[i] = 1'b0;
        end
    end

    for (genvar j = 0; j < GPE_W; j++) begin : g_gpe
        assign gpe_hit[j] = gpe_en_q[j] & gpe_sts_q[j];
    end

    assign sci = (|pair_hit) | (|gpe_hit);

endmodule

// File: rtl/pm_evt_sci.sv
`timescale 1ns/1ps
module pm_evt_sci
    import pm_evt_pkg::*;
#(
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = 'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [1:0]       bus_addr,
    input  logic [1:0]       bus_size,
    input  logic [15:0]      bus_wdata,
    output logic [15:0]      bus_rdata,
    input  logic             pwrbtn_evt,
    input  logic             btn_arm,
    input  logic             rtc_evt,
    input  logic [GPE_W-1:0] gpe_evt,
    output logic             sci
);

    wr_strb_t         wstrb;
    logic [15:0]      main_sts_q;
    logic [15:0]      main_en_q;
    logic [GPE_W-1:0] gpe_sts_q;
    logic [GPE_W-1:0] gpe_en_q;

    pm_bus_decode #(.GPE_W(GPE_W)) u_dec (
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .main_sts_q (main_sts_q),
        .main_en_q  (main_en_q),
        .gpe_sts_q  (gpe_sts_q),
        .gpe_en_q   (gpe_en_q),
        .wstrb      (wstrb),
        .bus_rdata  (bus_rdata)
    );

    pm_evt_regs #(.GPE_W(GPE_W), .GPE_VALID(GPE_VALID)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wstrb      (wstrb),
        .wdata      (bus_wdata),
        .pwrbtn_evt (pwrbtn_evt),
        .btn_arm    (btn_arm),
        .rtc_evt    (rtc_evt),
        .gpe_evt    (gpe_evt),
        .main_sts_q (main_sts_q),
        .main_en_q  (main_en_q),
        .gpe_sts_q  (gpe_sts_q),
        .gpe_en_q   (gpe_en_q)
    );

    pm_sci_gen #(.GPE_W(GPE_W)) u_sci (
        .main_sts_q (main_sts_q),
        .main_en_q  (main_en_q),
        .gpe_sts_q  (gpe_sts_q),
        .gpe_en_q   (gpe_en_q),
        .sci        (sci)
    );

endmodule

// File: rtl/pm_evt_sci_chk.sv
`timescale 1ns/1ps
module pm_evt_sci_chk
    import pm_evt_pkg::*;
#(
    parameter int               GPE_W     = 8,
    parameter logic [GPE_W-1:0] GPE_VALID = 'h01
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [1:0]       bus_addr,
    input logic [1:0]       bus_size,
    input logic [15:0]      bus_wdata,
    input logic [15:0]      bus_rdata,
    input logic             pwrbtn_evt,
    input logic             btn_arm,
    input logic             rtc_evt,
    input logic [GPE_W-1:0] gpe_evt,
    input logic             sci,
    input logic [15:0]      main_sts_q,
    input logic [15:0]      main_en_q,
    input logic [GPE_W-1:0] gpe_sts_q,
    input logic [GPE_W-1:0] gpe_en_q
);

    logic main_wr, bad_size_wr;
    assign main_wr     = bus_valid && bus_write && (bus_size == 2'd1);
    assign bad_size_wr = bus_valid && bus_write &&
                         (bus_addr[1] ? (bus_size != 2'd0) : (bus_size != 2'd1));

    // R1: registers and interrupt are clear on leaving reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (main_sts_q == '0 && main_en_q == '0 &&
                          gpe_sts_q == '0 && gpe_en_q == '0 && !sci));

    // R2: write-one-to-clear over the clearable mask only
    assert_sts_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && bus_addr == 2'd0 && !pwrbtn_evt && !rtc_evt) |=>
        (main_sts_q == ($past(main_sts_q) & ~($past(bus_wdata) & MAIN_STS_CLR_MASK))));

    // R3: enable write keeps only the writable bits
    assert_en_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_wr && bus_addr == 2'd1) |=> (main_en_q == ($past(bus_wdata) & MAIN_EN_WR_MASK)));

    // R4: no status or no enable means no interrupt
    assert_sci_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_sts_q == '0 && gpe_sts_q == '0) || (main_en_q == '0 && gpe_en_q == '0)) |-> !sci);

    // R5: a power-button pulse is dropped while not armed
    assert_btn_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && !btn_arm && !main_sts_q[BIT_PWRBTN]) |=> !main_sts_q[BIT_PWRBTN]);

    // R6: a valid generic event always lands in status
    assert_gpe_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gpe_evt & GPE_VALID)) |=>
        ((gpe_sts_q & $past(gpe_evt & GPE_VALID)) == $past(gpe_evt & GPE_VALID)));

    // R7: a write of the wrong size leaves the enables alone
    assert_bad_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bad_size_wr |=> ($stable(main_en_q) && $stable(gpe_en_q)));

    // R8: events beat a same-cycle clear
    assert_rtc_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_evt |=> main_sts_q[BIT_RTC]);
    assert_btn_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrbtn_evt && btn_arm) |=> main_sts_q[BIT_PWRBTN]);

    // R9: an accepted enable read returns the stored value
    assert_rd_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 2'd1 && bus_size == 2'd1) |-> (bus_rdata == main_en_q));

endmodule

bind pm_evt_sci pm_evt_sci_chk #(.GPE_W(GPE_W), .GPE_VALID(GPE_VALID)) u_chk (.*);

// File: tb/sim_pm_evt_sci.sv
`timescale 1ns/1ps
module sim_pm_evt_sci;

    localparam int GPE_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_write = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [1:0]       bus_size = '0;
    logic [15:0]      bus_wdata = '0;
    logic [15:0]      bus_rdata;
    logic             pwrbtn_evt = 1'b0;
    logic             btn_arm = 1'b0;
    logic             rtc_evt = 1'b0;
    logic [GPE_W-1:0] gpe_evt = '0;
    logic             sci;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pm_evt_sci u0 (.*);

    // register select: 0 main status, 1 main enable, 2 GPE status, 3 GPE enable
    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  evt;    // {power button, rtc, gpe line 0}
        logic        wen;
        logic [1:0]  waddr;
        logic [15:0] wdata;
        logic [1:0]  raddr;
        logic [15:0] exp;
        logic        exp_sci;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{4'd5, 3'b100, 1'b0, 2'd0, 16'h0000, 2'd0, 16'h0100, 1'b0}, // R5 button sets bit 8
        '{4'd3, 3'b000, 1'b1, 2'd1, 16'hFFFF, 2'd1, 16'h0520, 1'b1}, // R3 enable mask
        '{4'd2, 3'b000, 1'b1, 2'd0, 16'h00EF, 2'd0, 16'h0100, 1'b1}, // R2 other bits ignored
        '{4'd2, 3'b000, 1'b1, 2'd0, 16'h0100, 2'd0, 16'h0000, 1'b0}, // R2 clear bit 8
        '{4'd4, 3'b010, 1'b0, 2'd0, 16'h0000, 2'd0, 16'h0400, 1'b1}, // R4 rtc enabled
        '{4'd4, 3'b000, 1'b1, 2'd1, 16'h0100, 2'd1, 16'h0100, 1'b0}, // R4 rtc disabled
        '{4'd2, 3'b000, 1'b1, 2'd0, 16'h7AEF, 2'd0, 16'h0400, 1'b0}, // R2 zero at bit 10
        '{4'd2, 3'b000, 1'b1, 2'd0, 16'h8400, 2'd0, 16'h0000, 1'b0}, // R2 clear bit 10
        '{4'd6, 3'b001, 1'b0, 2'd0, 16'h0000, 2'd2, 16'h0001, 1'b0}, // R6 gpe sets
        '{4'd6, 3'b000, 1'b1, 2'd3, 16'h00FF, 2'd3, 16'h0001, 1'b1}, // R6 gpe enable valid only
        '{4'd6, 3'b000, 1'b1, 2'd2, 16'h00FE, 2'd2, 16'h0001, 1'b1}, // R6 clear outside valid
        '{4'd6, 3'b000, 1'b1, 2'd2, 16'h0001, 2'd2, 16'h0000, 1'b0}, // R6 clear valid
        '{4'd4, 3'b101, 1'b0, 2'd0, 16'h0000, 2'd0, 16'h0100, 1'b1}, // R4 two sources
        '{4'd4, 3'b000, 1'b1, 2'd1, 16'h0000, 2'd1, 16'h0000, 1'b1}, // R4 gpe keeps sci
        '{4'd4, 3'b000, 1'b1, 2'd3, 16'h0000, 2'd2, 16'h0001, 1'b0}  // R4 gpe disabled
    };

    function automatic logic [1:0] size_for(input logic [1:0] a);
        return a[1] ? 2'd0 : 2'd1;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [1:0] sz, input logic [15:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [1:0] sz, output logic [15:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic pulse(input logic pb, input logic rt, input logic [GPE_W-1:0] g);
        @(negedge clk);
        pwrbtn_evt = pb; rtc_evt = rt; gpe_evt = g;
        @(negedge clk);
        pwrbtn_evt = 1'b0; rtc_evt = 1'b0; gpe_evt = '0;
    endtask

    task automatic clear_all();
        bus_wr(2'd0, 2'd1, 16'hFFFF);
        bus_wr(2'd1, 2'd1, 16'h0000);
        bus_wr(2'd2, 2'd0, 16'h00FF);
        bus_wr(2'd3, 2'd0, 16'h0000);
    endtask

    task automatic check_all_zero(input string tag);
        logic [15:0] r;
        for (int a = 0; a < 4; a++) begin
            bus_rd(2'(a), size_for(2'(a)), r);
            check(tag, r, 16'h0000);
        end
        check(tag, {15'd0, sci}, 16'h0000);
    endtask

    initial begin
        #(100000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all_zero("R1 reset");

        // table walk (R2 R3 R4 R5 R6)
        btn_arm = 1'b1;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].evt != 3'b000) begin
                pulse(VEC[i].evt[2], VEC[i].evt[1], {{(GPE_W-1){1'b0}}, VEC[i].evt[0]});
            end
            if (VEC[i].wen) begin
                bus_wr(VEC[i].waddr, size_for(VEC[i].waddr), VEC[i].wdata);
            end
            bus_rd(VEC[i].raddr, size_for(VEC[i].raddr), r);
            check($sformatf("R%0d table %0d rdata", VEC[i].req, i), r, VEC[i].exp);
            check($sformatf("R%0d table %0d sci", VEC[i].req, i), {15'd0, sci}, {15'd0, VEC[i].exp_sci});
        end
        clear_all();

        // R7 wrong-size writes and reads
        bus_wr(2'd1, 2'd0, 16'hFFFF);
        bus_wr(2'd1, 2'd2, 16'hFFFF);
        bus_wr(2'd3, 2'd1, 16'h00FF);
        bus_wr(2'd3, 2'd3, 16'h00FF);
        bus_rd(2'd1, 2'd1, r); check("R7 main enable after bad sizes", r, 16'h0000);
        bus_rd(2'd3, 2'd0, r); check("R7 gpe enable after bad sizes", r, 16'h0000);
        bus_wr(2'd1, 2'd1, 16'h0520);
        bus_rd(2'd1, 2'd0, r); check("R7 byte read of main enable", r, 16'h0000);
        bus_rd(2'd1, 2'd1, r); check("R7 half read of main enable", r, 16'h0520);
        // R9 no accepted read -> zero
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = 2'd1; bus_size = 2'd1;
        #1; check("R9 idle rdata", bus_rdata, 16'h0000);
        clear_all();

        // R5 unarmed button
        btn_arm = 1'b0;
        pulse(1'b1, 1'b0, '0);
        bus_rd(2'd0, 2'd1, r); check("R5 unarmed button", r, 16'h0000);
        pulse(1'b0, 1'b1, '0);
        bus_rd(2'd0, 2'd1, r); check("R5 rtc while unarmed", r, 16'h0400);
        btn_arm = 1'b1;

        // R8 event beats same-cycle clear
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd0; bus_size = 2'd1; bus_wdata = 16'h0500;
        rtc_evt = 1'b1; pwrbtn_evt = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; rtc_evt = 1'b0; pwrbtn_evt = 1'b0;
        bus_rd(2'd0, 2'd1, r); check("R8 main status kept", r, 16'h0500);
        pulse(1'b0, 1'b0, 8'h01);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd2; bus_size = 2'd0; bus_wdata = 16'h0001;
        gpe_evt = 8'h01;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; gpe_evt = '0;
        bus_rd(2'd2, 2'd0, r); check("R8 gpe status kept", r, 16'h0001);
        clear_all();

        // R6 invalid gpe lines ignored
        pulse(1'b0, 1'b0, 8'hFE);
        bus_rd(2'd2, 2'd0, r); check("R6 invalid gpe lines", r, 16'h0000);

        // R4 level holds until cleared
        bus_wr(2'd1, 2'd1, 16'h0400);
        pulse(1'b0, 1'b1, '0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R4 level held", {15'd0, sci}, 16'h0001);
        end
        bus_wr(2'd0, 2'd1, 16'h0400);
        check("R4 level drops on clear", {15'd0, sci}, 16'h0000);

        // R1 reset in mid-run
        bus_wr(2'd3, 2'd0, 16'h0001);
        pulse(1'b1, 1'b1, 8'h01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all_zero("R1 mid-run reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule